// File: doc/BRIEF.md
# Synchronous Serial Master Shift Engine

This block runs one word-wide transfer at a time as the clock-generating end of a synchronous serial link. A start strobe captures the transmit word, the divider value and the two clock-shape bits. The engine then steps through one bit period per data bit. Each bit period is split into a leading half and a trailing half. Each half lasts a programmable number of system cycles.

The internal timeline of a bit period never changes. The shift register is loaded when the transfer starts. The incoming serial bit is captured at the midpoint. The shift register advances at the end of the period. The two shape bits only control the serial clock output. One selects the level the clock rests at, and therefore which way its single pulse goes. The other selects whether the pulse sits in the leading or the trailing half. After the final period, the assembled word is copied into a receive buffer and a one-cycle completion pulse is raised.

Top module: `ssm_master`

## Requirements
- R1: While no transfer is in progress, `sclk_o` equals the live `idle_hi_i` input.
- R2: During a transfer, each bit period holds `sclk_o` at the captured rest level for one half and at the opposite level for the other half. The pulse occupies the leading half when the captured `pulse_lead_i` is 1, and the trailing half when it is 0.
- R3: Each half-period lasts `divider_i + 1` system cycles. `busy_o` rises in the cycle after an accepted start and stays high for exactly 2·WORD_W·(divider+1) cycles.
- R4: `sdi_i` is sampled only on the last system cycle of the leading half of each bit period. Its value in any other cycle has no effect on the received word.
- R5: `sdo_o` presents the transmit word most-significant bit first. Bit k (counting from 0) is held for the whole of bit period k.
- R6: When the last bit period ends, `rx_word_o` takes the captured bits, first-captured bit in the MSB. In that same cycle `done_o` is high for exactly one cycle and `busy_o` is low.
- R7: A start strobe while `busy_o` is high is ignored: timing and transmit data stay unchanged. `rx_word_o` changes only in a cycle where `done_o` is high.
- R8: The divider, rest level and pulse position are captured at start. Changing those inputs during a transfer has no effect on `sclk_o` or on the transfer's timing.
- R9: After reset, `busy_o`, `done_o`, `sdo_o` and `rx_word_o` are zero. `sdo_o` is zero whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| tx_word_i | input | WORD_W | Word to transmit, captured at start |
| idle_hi_i | input | 1 | Clock rest level: 1 rests high, 0 rests low |
| pulse_lead_i | input | 1 | 1 puts the clock pulse in the leading half, 0 in the trailing half |
| divider_i | input | DIV_W | Half-period length minus one, in system cycles |
| sdi_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| rx_word_o | output | WORD_W | Receive buffer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the receive buffer is written |

## Verification
All four combinations of rest level and pulse position are run in loopback with different divider values. A swapped or inverted shape shows up as an `sclk_o` mismatch in a particular half. A wrong divider shows up as a half boundary in the wrong cycle. A second set of runs drives `sdi_i` with the intended bit only in the midpoint cycle and its inverse in every other cycle. A sample point moved by even one cycle then corrupts the received word, which loopback cannot reveal. One run changes the divider and both shape bits mid-transfer and fires an extra start. This separates captured configuration from live configuration.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

   // Which half of a bit period the sequencer is in.
   typedef enum logic {
      HALF_LEAD  = 1'b0,
      HALF_TRAIL = 1'b1
   } half_e;

   // Serial clock shape captured at the start of a transfer.
   typedef struct packed {
      logic idle_hi;     // rest level of the serial clock
      logic pulse_lead;  // pulse placed in the leading half
   } clk_cfg_t;

endpackage

// File: rtl/ssm_baud.sv
module ssm_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   if (DIV_W < 1) begin : g_bad_div
      $error("ssm_baud: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (cnt_q == div_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = run_i && (cnt_q == div_i);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q <= div_i)); // R3

endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
   parameter int WORD_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              latch_i,
   input  logic              shift_i,
   input  logic              last_i,
   input  logic [WORD_W-1:0] tx_word_i,
   input  logic              sdi_i,
   output logic              out_bit_o,
   output logic [WORD_W-1:0] rx_word_o
);

   if (WORD_W < 2) begin : g_bad_width
      $error("ssm_shifter: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] sreg_q;
   logic [WORD_W-1:0] sreg_next;
   logic [WORD_W-1:0] rx_q;
   logic              samp_q;

   if (MSB_FIRST) begin : g_msb
      assign sreg_next = {sreg_q[WORD_W-2:0], samp_q};
      assign out_bit_o = sreg_q[WORD_W-1];
   end else begin : g_lsb
      assign sreg_next = {samp_q, sreg_q[WORD_W-1:1]};
      assign out_bit_o = sreg_q[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         samp_q <= 1'b0;
         rx_q   <= '0;
      end else begin
         if (load_i) begin
            sreg_q <= tx_word_i;
         end else if (shift_i) begin
            sreg_q <= sreg_next;
            if (last_i) begin
               rx_q <= sreg_next;
            end
         end
         if (latch_i) begin
            samp_q <= sdi_i;
         end
      end
   end

   assign rx_word_o = rx_q;

   AST_LATCH_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(latch_i && shift_i)); // R4

   AST_RX_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !(shift_i && last_i) |=> $stable(rx_q)); // R7

endmodule

// File: rtl/ssm_clkshape.sv
module ssm_clkshape
   import ssm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     busy_i,
   input  half_e    half_i,
   input  clk_cfg_t cfg_i,
   input  logic     idle_hi_live_i,
   output logic     sclk_o
);

   logic in_pulse;

   always_comb begin
      if (cfg_i.pulse_lead) begin
         in_pulse = (half_i == HALF_LEAD);
      end else begin
         in_pulse = (half_i == HALF_TRAIL);
      end
   end

   always_comb begin
      if (busy_i) begin
         sclk_o = cfg_i.idle_hi ^ in_pulse;
      end else begin
         sclk_o = idle_hi_live_i;
      end
   end

   AST_SCLK_STEADY_IN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && $past(busy_i) && (half_i == $past(half_i))) |-> $stable(sclk_o)); // R2

endmodule

// File: rtl/ssm_master.sv
module ssm_master
   import ssm_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] tx_word_i,
   input  logic              idle_hi_i,
   input  logic              pulse_lead_i,
   input  logic [DIV_W-1:0]  divider_i,
   input  logic              sdi_i,
   output logic              sclk_o,
   output logic              sdo_o,
   output logic [WORD_W-1:0] rx_word_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

   if (WORD_W < 2) begin : g_bad_word
      $error("ssm_master: WORD_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("ssm_master: DIV_W must be at least 1");
   end

   logic             busy_q;
   logic             done_q;
   half_e            half_q;
   logic [BIT_W-1:0] bit_q;
   logic [DIV_W-1:0] div_q;
   clk_cfg_t         cfg_q;

   logic start_acc;
   logic tick;
   logic at_mid;
   logic at_end;
   logic last_bit;
   logic out_bit;

   assign start_acc = start_i && !busy_q;
   assign at_mid    = busy_q && tick && (half_q == HALF_LEAD);
   assign at_end    = busy_q && tick && (half_q == HALF_TRAIL);
   assign last_bit  = (bit_q == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         half_q <= HALF_LEAD;
         bit_q  <= '0;
         div_q  <= '0;
         cfg_q  <= '0;
      end else begin
         done_q <= at_end && last_bit;
         if (start_acc) begin
            busy_q           <= 1'b1;
            half_q           <= HALF_LEAD;
            bit_q            <= '0;
            div_q            <= divider_i;
            cfg_q.idle_hi    <= idle_hi_i;
            cfg_q.pulse_lead <= pulse_lead_i;
         end else if (at_mid) begin
            half_q <= HALF_TRAIL;
         end else if (at_end) begin
            half_q <= HALF_LEAD;
            if (last_bit) begin
               busy_q <= 1'b0;
            end else begin
               bit_q <= bit_q + 1'b1;
            end
         end
      end
   end

   ssm_baud #(
      .DIV_W (DIV_W)
   ) u_baud (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (busy_q),
      .div_i  (div_q),
      .tick_o (tick)
   );

   ssm_shifter #(
      .WORD_W    (WORD_W),
      .MSB_FIRST (1'b1)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start_acc),
      .latch_i   (at_mid),
      .shift_i   (at_end),
      .last_i    (last_bit),
      .tx_word_i (tx_word_i),
      .sdi_i     (sdi_i),
      .out_bit_o (out_bit),
      .rx_word_o (rx_word_o)
   );

   ssm_clkshape u_shape (
      .clk            (clk),
      .rst_n          (rst_n),
      .busy_i         (busy_q),
      .half_i         (half_q),
      .cfg_i          (cfg_q),
      .idle_hi_live_i (idle_hi_i),
      .sclk_o         (sclk_o)
   );

   assign sdo_o  = busy_q ? out_bit : 1'b0;
   assign busy_o = busy_q;
   assign done_o = done_q;

   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (sclk_o == idle_hi_i)); // R1

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6

   AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o))); // R6

   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(rx_word_o)); // R7

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(div_q) && $stable(cfg_q))); // R8

   AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !$past(busy_o)) |-> !sdo_o); // R9

endmodule

// File: tb/tb_ssm_master.sv
module tb_ssm_master;

   localparam int W  = 8;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  tx = '0;
   logic          idle_hi = 1'b1;
   logic          pulse_lead = 1'b0;
   logic [DW-1:0] divider = '0;
   logic          sdi;
   logic          sdi_drv = 1'b0;
   logic          loop = 1'b1;
   logic          sclk, sdo, busy, done;
   logic [W-1:0]  rx;

   always #10 clk = ~clk;

   assign sdi = loop ? sdo : sdi_drv;

   ssm_master #(.WORD_W(W), .DIV_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .tx_word_i(tx),
      .idle_hi_i(idle_hi), .pulse_lead_i(pulse_lead), .divider_i(divider),
      .sdi_i(sdi), .sclk_o(sclk), .sdo_o(sdo), .rx_word_o(rx),
      .busy_o(busy), .done_o(done)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Reference model state
   bit         model_on = 0;
   bit         want_start = 0;
   bit         done_pend = 0;
   bit         model_loop = 1;
   int         kc = 0;
   int         total = 0;
   int         d_m = 0;
   bit         pol_m = 0;
   bit         lead_m = 0;
   logic [W-1:0] tx_m = '0;
   logic [W-1:0] pat_m = '0;
   logic [W-1:0] exp_rx = '0;
   logic [W-1:0] pend_rx = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         bit done_now;
         done_now = done_pend;
         done_pend = 0;
         if (!model_on && want_start && busy) begin
            model_on = 1;
            want_start = 0;
            kc = 0;
         end
         if (model_on) begin
            int hp, ph, p;
            bit exp_sclk;
            hp = d_m + 1;
            ph = (kc / hp) % 2;
            p  = kc / (2 * hp);
            exp_sclk = pol_m ^ (lead_m ? (ph == 0) : (ph == 1));
            chk(busy == 1'b1, "R3 busy during transfer", busy, 1);
            chk(sclk == exp_sclk, "R2 pulse position/direction", sclk, exp_sclk);
            chk(sdo == tx_m[W-1-p], "R5 serial out bit", sdo, tx_m[W-1-p]);
            chk(done == 1'b0, "R6 no done mid-transfer", done, 0);
            chk(rx == exp_rx, "R7 rx held during transfer", rx, exp_rx);
            sdi_drv = ((kc % (2 * hp)) == d_m) ? pat_m[W-1-p] : ~pat_m[W-1-p];
            kc++;
            if (kc == total) begin
               model_on = 0;
               done_pend = 1;
               pend_rx = model_loop ? tx_m : pat_m;
            end
         end else begin
            if (done_now) exp_rx = pend_rx;
            chk(busy == 1'b0, "R3 busy low when idle", busy, 0);
            chk(sclk == idle_hi, "R1 idle clock level", sclk, idle_hi);
            chk(sdo == 1'b0, "R9 sdo quiet when idle", sdo, 0);
            chk(done == done_now, "R6 done pulse", done, done_now);
            chk(rx == exp_rx, done_now ? "R6 R4 received word" : "R7 rx stable",
                rx, exp_rx);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic xfer(input bit pol, input bit lead, input int d,
                       input logic [W-1:0] word, input logic [W-1:0] pat,
                       input bit lb, input bit disturb);
      @(posedge clk); #2;
      loop = lb;
      idle_hi = pol; pulse_lead = lead; divider = DW'(d); tx = word;
      pol_m = pol; lead_m = lead; d_m = d; tx_m = word; pat_m = pat;
      model_loop = lb; total = 2 * W * (d + 1);
      start = 1'b1; want_start = 1;
      @(posedge clk); #2;
      start = 1'b0;
      if (disturb) begin
         repeat (5) @(posedge clk);
         #2;
         // R7: extra start with a different word; R8: live config changes
         start = 1'b1; tx = ~word; divider = DW'(d + 3);
         idle_hi = ~pol; pulse_lead = ~lead;
         @(posedge clk); #2;
         start = 1'b0;
         repeat (4) @(posedge clk);
         #2;
         idle_hi = pol;
      end
      while (want_start || model_on || done_pend) @(posedge clk);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state, R1 clock rests at live level during reset
      chk(busy == 1'b0, "R9 reset busy", busy, 0);
      chk(done == 1'b0, "R9 reset done", done, 0);
      chk(sdo == 1'b0, "R9 reset sdo", sdo, 0);
      chk(rx == '0, "R9 reset rx", rx, 0);
      chk(sclk == 1'b1, "R1 reset idle high", sclk, 1);
      idle_hi = 1'b0;
      #1;
      chk(sclk == 1'b0, "R1 reset idle low", sclk, 0);
      @(posedge clk); #2;
      rst_n = 1'b1;

      // R2 R3 R5 R6: all four shapes, loopback
      xfer(1'b0, 1'b0, 0, 8'hA5, 8'h00, 1'b1, 1'b0);
      xfer(1'b0, 1'b1, 1, 8'h3C, 8'h00, 1'b1, 1'b0);
      xfer(1'b1, 1'b0, 2, 8'h81, 8'h00, 1'b1, 1'b0);
      xfer(1'b1, 1'b1, 3, 8'h5E, 8'h00, 1'b1, 1'b0);
      // R4: sdi valid only in the midpoint cycle
      xfer(1'b0, 1'b0, 3, 8'hF0, 8'hC3, 1'b0, 1'b0);
      xfer(1'b1, 1'b1, 2, 8'h0F, 8'h96, 1'b0, 1'b0);
      xfer(1'b1, 1'b0, 0, 8'h00, 8'h6B, 1'b0, 1'b0);
      // R7 R8: ignored start and live config changes mid-transfer
      xfer(1'b0, 1'b1, 2, 8'hD2, 8'h00, 1'b1, 1'b1);
      xfer(1'b1, 1'b0, 1, 8'hFF, 8'h2A, 1'b0, 1'b1);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule